// File: doc/BRIEF.md
# Packed Decimal Byte Adder

The block adds two packed decimal bytes, each holding two decimal digits of four bits, together with a carry-in. It first forms a plain unsigned binary sum and records the carry out of the low digit (half carry) and the carry out of the byte. It then runs a fixed, ordered pair of decimal corrections: a low-digit fix, then a high-digit fix that sees the byte the first fix left behind. The outcome is a corrected byte, an auxiliary flag and a carry flag. The carry-in lets several units be chained for multi-byte decimal sums.

Operands enter on a valid/ready handshake. The result and both flags sit in an output register one cycle after acceptance. `out_valid` stays high, with the data held steady, until `out_ready` is seen high. While a result is held and not drained, `in_ready` is low. A new operand pair may be accepted in the same cycle that the held result drains.

Top module: `bcd_adder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The raw sum is `in_a + in_b + in_cin` truncated to 8 bits. Bits [3:0] form the low digit and bits [7:4] the high digit. The half carry is the carry out of bit 3, and the binary carry is the carry out of bit 7.
- R3: The low fix applies when the raw low digit exceeds 9 or the half carry is 1. When it applies, 0x06 is added to the byte (truncated to 8 bits) and `out_aux` is 1. Otherwise the byte is unchanged and `out_aux` is 0.
- R4: The high fix tests the byte produced by the low fix, not the raw sum. It applies when that byte exceeds 0x9F or the carry flag is 1. When it applies, 0x60 is added (truncated) and `out_carry` is 1. Otherwise `out_carry` is 0.
- R5: The carry flag fed into the high fix is the binary carry ORed with any carry out of bit 7 from the low-fix addition. A carry out of the high-fix addition also forces `out_carry` to 1.
- R6: For operands whose four digits are all 0..9, `out_sum` is the two-digit decimal value of (a+b+cin) mod 100, `out_carry` is 1 exactly when the total is 100 or more, and `out_aux` is 1 exactly when the low digits plus cin reach 10.
- R7: A pair accepted on a clock edge (`in_valid` and `in_ready` both 1) appears with `out_valid` = 1 right after that edge, and not earlier.
- R8: While `out_valid` is 1 and `out_ready` is 0, the outputs `out_valid`, `out_sum`, `out_aux` and `out_carry` hold their values, and `in_ready` is 0.
- R9: `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1, so a drain and a new acceptance can share one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 8 | First packed decimal operand |
| in_b | input | 8 | Second packed decimal operand |
| in_cin | input | 1 | Carry-in added into the binary sum |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the held result |
| out_sum | output | 8 | Corrected byte |
| out_aux | output | 1 | Auxiliary flag after the low fix |
| out_carry | output | 1 | Carry flag after the high fix |

## Verification
The bench builds the block with its package defaults: two four-bit digits per byte and correction constants 0x06 and 0x60. Because the operand space is small at these values, every valid decimal pair with both carry-in values can be swept and compared against plain decimal arithmetic. The same build also allows directed cases that reach the orderings and wrap-arounds only non-decimal operands produce. These include a low fix that wraps past 0xFF, and a high fix that triggers only because the low fix moved the byte past 0x9F.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIG_W  = 4;
  localparam int NDIG   = 2;
  localparam int BYTE_W = DIG_W * NDIG;

  typedef logic [BYTE_W-1:0] byte_t;

  // Largest legal digit and the distance from it to the next power of two.
  localparam int DIG_MAX = 9;
  localparam int DIG_GAP = (1 << DIG_W) - (DIG_MAX + 1);

  // Low fix: test the low digit alone against the largest legal digit.
  localparam byte_t LO_MASK  = byte_t'((1 << DIG_W) - 1);
  localparam byte_t LO_LIMIT = byte_t'(DIG_MAX);
  localparam byte_t LO_ADD   = byte_t'(DIG_GAP);

  // High fix: test the whole byte against "largest digit, then all ones".
  localparam byte_t HI_MASK  = '1;
  localparam byte_t HI_LIMIT = byte_t'((DIG_MAX << DIG_W) | ((1 << DIG_W) - 1));
  localparam byte_t HI_ADD   = byte_t'(DIG_GAP << DIG_W);
endpackage

// File: rtl/bcd_binsum.sv
module bcd_binsum
  import bcd_pkg::*;
(
  input  byte_t a,
  input  byte_t b,
  input  logic  cin,
  output byte_t sum,
  output logic  half_carry,
  output logic  carry
);
  logic [NDIG:0] cy;
  assign cy[0] = cin;

  // Ripple one digit at a time so the carry out of every digit boundary is visible.
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [DIG_W:0] t;
    assign t = {1'b0, a[g*DIG_W +: DIG_W]} + {1'b0, b[g*DIG_W +: DIG_W]}
             + {{DIG_W{1'b0}}, cy[g]};
    assign sum[g*DIG_W +: DIG_W] = t[DIG_W-1:0];
    assign cy[g+1] = t[DIG_W];
  end

  assign half_carry = cy[1];
  assign carry      = cy[NDIG];
endmodule

// File: rtl/bcd_fix_step.sv
module bcd_fix_step #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK   = '1,
  parameter logic [W-1:0] LIMIT  = '0,
  parameter logic [W-1:0] ADDEND = '0
) (
  input  logic [W-1:0] v_in,
  input  logic         flag_in,
  output logic [W-1:0] v_out,
  output logic         flag_out,
  output logic         wrap_out
);
  logic         hit;
  logic [W:0]   t;

  assign hit      = ((v_in & MASK) > LIMIT) || flag_in;
  assign t        = {1'b0, v_in} + {1'b0, ADDEND};
  assign v_out    = hit ? t[W-1:0] : v_in;
  assign flag_out = hit;
  assign wrap_out = hit & t[W];
endmodule

// File: rtl/bcd_out_slice.sv
module bcd_out_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_valid && s_ready) begin
      m_valid <= 1'b1;
      m_data  <= s_data;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bcd_adder.sv
module bcd_adder
  import bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_a,
  input  logic [7:0] in_b,
  input  logic       in_cin,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_sum,
  output logic       out_aux,
  output logic       out_carry
);
  localparam int PAY_W = BYTE_W + 2;

  byte_t raw_sum, lo_sum, hi_sum;
  logic  raw_hc, raw_cy;
  logic  lo_flag, lo_wrap, hi_flag, hi_wrap;
  logic  cy_into_hi;
  logic [PAY_W-1:0] pay_d, pay_q;

  bcd_binsum u_sum (
    .a          (in_a),
    .b          (in_b),
    .cin        (in_cin),
    .sum        (raw_sum),
    .half_carry (raw_hc),
    .carry      (raw_cy)
  );

  bcd_fix_step #(.W(BYTE_W), .MASK(LO_MASK), .LIMIT(LO_LIMIT), .ADDEND(LO_ADD)) u_lo (
    .v_in     (raw_sum),
    .flag_in  (raw_hc),
    .v_out    (lo_sum),
    .flag_out (lo_flag),
    .wrap_out (lo_wrap)
  );

  // A wrap out of the low fix is a decimal carry that the high fix must see.
  assign cy_into_hi = raw_cy | lo_wrap;

  bcd_fix_step #(.W(BYTE_W), .MASK(HI_MASK), .LIMIT(HI_LIMIT), .ADDEND(HI_ADD)) u_hi (
    .v_in     (lo_sum),
    .flag_in  (cy_into_hi),
    .v_out    (hi_sum),
    .flag_out (hi_flag),
    .wrap_out (hi_wrap)
  );

  assign pay_d = {hi_flag | hi_wrap, lo_flag, hi_sum};

  bcd_out_slice #(.W(PAY_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pay_d),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pay_q)
  );

  assign out_sum   = pay_q[BYTE_W-1:0];
  assign out_aux   = pay_q[BYTE_W];
  assign out_carry = pay_q[BYTE_W+1];
endmodule

// File: rtl/bcd_adder_chk.sv
module bcd_adder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_a,
  input logic [7:0] in_b,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_sum,
  input logic       out_aux,
  input logic       out_carry
);
  logic dec_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_ok_q <= 1'b0;
    else if (in_valid && in_ready)
      dec_ok_q <= (in_a[3:0] <= 4'd9) && (in_a[7:4] <= 4'd9) &&
                  (in_b[3:0] <= 4'd9) && (in_b[7:4] <= 4'd9);
  end

  assert_accept_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) &&
                                   $stable(out_aux) && $stable(out_carry)));

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_ready_rule_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  assert_digits_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dec_ok_q) |-> ((out_sum[3:0] <= 4'd9) && (out_sum[7:4] <= 4'd9)));
endmodule

bind bcd_adder bcd_adder_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum),
  .out_aux   (out_aux),
  .out_carry (out_carry)
);

// File: tb/bcd_adder_tb_top.sv
`timescale 1ns/1ps
module bcd_adder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       in_cin = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_sum;
  logic       out_aux;
  logic       out_carry;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bcd_adder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_cin    (in_cin),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sum   (out_sum),
    .out_aux   (out_aux),
    .out_carry (out_carry)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one pair, let it be captured, and compare the registered result.
  task automatic run_one(input string req, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic [7:0] e_sum, input logic e_aux,
                         input logic e_cy);
    @(negedge clk);
    in_a = a; in_b = b; in_cin = c; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " sum"},   32'(out_sum),   32'(e_sum));
    chk({req, " aux"},   32'(out_aux),   32'(e_aux));
    chk({req, " carry"}, 32'(out_carry), 32'(e_cy));
  endtask

  task automatic t_reset;
    #1;
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1 in_ready in reset",  32'(in_ready),  32'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 in_ready after reset",  32'(in_ready),  32'd1);
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_a = 8'h12; in_b = 8'h34; in_cin = 1'b0; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk("R7 no output before capture edge", 32'(out_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 output one edge after accept", 32'(out_valid), 32'd1);
    chk("R7 sum 12+34", 32'(out_sum), 32'h46);
    @(negedge clk);
    chk("R7 drained", 32'(out_valid), 32'd0);
  endtask

  task automatic t_corners;
    run_one("R6 99+01",       8'h99, 8'h01, 1'b0, 8'h00, 1'b1, 1'b1);
    run_one("R6 09+09",       8'h09, 8'h09, 1'b0, 8'h18, 1'b1, 1'b0);
    run_one("R6 99+99+cin",   8'h99, 8'h99, 1'b1, 8'h99, 1'b1, 1'b1);
    run_one("R2 cin 00+00",   8'h00, 8'h00, 1'b1, 8'h01, 1'b0, 1'b0);
    run_one("R6 45+55",       8'h45, 8'h55, 1'b0, 8'h00, 1'b1, 1'b1);
  endtask

  // Non-decimal operands reach the raw rules directly; values worked by hand.
  task automatic t_raw_rules;
    run_one("R3 low digit A", 8'h0A, 8'h00, 1'b0, 8'h10, 1'b1, 1'b0);
    run_one("R3 half carry",  8'h0F, 8'h01, 1'b0, 8'h16, 1'b1, 1'b0);
    run_one("R4 binary carry",8'hF0, 8'h10, 1'b0, 8'h60, 1'b0, 1'b1);
    run_one("R4 order 9A",    8'h9A, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1);
    run_one("R4 high only",   8'hB0, 8'h00, 1'b0, 8'h10, 1'b0, 1'b1);
    run_one("R5 low wrap",    8'h99, 8'h61, 1'b0, 8'h60, 1'b1, 1'b1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 8'h27; in_b = 8'h15; in_cin = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_a = 8'h50; in_b = 8'h50; in_cin = 1'b1;
    chk("R8 held valid", 32'(out_valid), 32'd1);
    chk("R8 in_ready low", 32'(in_ready), 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 sum held", 32'(out_sum), 32'h42);
      chk("R8 carry held", 32'(out_carry), 32'd0);
      chk("R8 stall keeps in_ready low", 32'(in_ready), 32'd0);
    end
    out_ready = 1'b1;
    #1;
    chk("R9 in_ready with out_ready", 32'(in_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second pair valid", 32'(out_valid), 32'd1);
    chk("R9 second pair sum", 32'(out_sum), 32'h01);
    chk("R9 second pair carry", 32'(out_carry), 32'd1);
  endtask

  task automatic t_sweep;
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        for (int c = 0; c < 2; c++) begin
          int s, lo;
          logic [7:0] a, b, e;
          s  = x + y + c;
          lo = (x % 10) + (y % 10) + c;
          a  = 8'(((x / 10) << 4) | (x % 10));
          b  = 8'(((y / 10) << 4) | (y % 10));
          e  = 8'((((s % 100) / 10) << 4) | (s % 10));
          run_one("R6 sweep", a, b, c[0], e, lo >= 10, s >= 100);
        end
      end
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_corners();
    t_raw_rules();
    t_backpressure();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule